// File: doc/BRIEF.md
# Phase-Domain Subcarrier Channel Equalizer

This block estimates and removes the channel on OFDM subcarriers without complex arithmetic. An earlier stage converts each received subcarrier to an unsigned phase word, a fraction of a full turn. The block gets that phase, a slot number and a mode bit. In a training cycle the known transmitted value is +1 or -1. Dividing by it is therefore either nothing or a half-turn shift. The resulting channel phase goes to a per-subcarrier register file and also to the output. In a data cycle the stored channel phase is subtracted from the received phase, and the difference is the equalized phase. The wrap at a full turn is the natural overflow of the phase word.

Two lanes run side by side, and each takes one subcarrier per clock. Lane `l` owns the subcarriers whose index is `slot*LANES + l`, so each lane has its own bank and the lanes never contend for an entry. Every result leaves six register stages after its input.

Top module: `phase_eq_top`

## Requirements
- R1: After reset, `outValid` stays 0 for the first six clock edges. Every stored channel phase is 0, so a data input before any training comes out unchanged.
- R2: An input captured at clock edge k produces a result after edge k+5. At that point `outValid` equals the input valid, and `outTrain` and `outSlot` equal the input mode and slot of that lane.
- R3: A valid training input with phase p on subcarrier s returns (p + F·2^(PH_W-1)) mod 2^PH_W. F is the known training sign: it is the parity of (s AND `TRAIN_MASK`), where 1 means -1, and s = slot*LANES + lane.
- R4: A valid data input with phase p returns (p − E) mod 2^PH_W, where E is the channel phase last stored for that lane and slot.
- R5: Data inputs leave the stored channel phase unchanged.
- R6: An input with valid low stores nothing, and it produces `outValid` 0 six stages later.
- R7: A data input in the cycle right after a training input to the same subcarrier uses the new estimate.
- R8: Training on one lane does not change the estimates of the other lane, including the same slot number in the same cycle.
- R9: A repeated training on a subcarrier replaces its stored estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | LANES | Per-lane input valid |
| inTrain | input | LANES | Per-lane mode: 1 training, 0 data |
| inPhase | input | LANES*PH_W | Per-lane received phase, lane l at bits [l*PH_W +: PH_W] |
| inSlot | input | LANES*SLOT_W | Per-lane slot within the lane's bank |
| outValid | output | LANES | Per-lane result valid |
| outTrain | output | LANES | Mode of the result |
| outPhase | output | LANES*PH_W | Channel phase (training) or equalized phase (data) |
| outSlot | output | LANES*SLOT_W | Slot of the result |

## Verification
The bench uses the default build: 10-bit phases, 128 subcarriers over two lanes of 64 slots each, and training mask 0x49. With this build, phase words near 0x3FF combined with a half-turn shift reach the modular wrap. Both training signs occur across slots. The 64-slot banks are small enough that random traffic retrains and re-reads the same entries many times. Directed cases cover a data read immediately after a write, and both lanes using the same slot number in the same cycle.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int PIPE_DEPTH = 6;

  typedef struct packed {
    logic wrEst;     // stage-1 entry is a valid training: update bank
    logic selTrain;  // stage-1 entry is training: forward the estimate
  } laneStrobe_t;

  // known training sign: 1 means the pilot value was -1
  function automatic logic trainFlip(input logic [15:0] sc, input logic [15:0] mask);
    return ^(sc & mask);
  endfunction
endpackage

// File: rtl/eq_ctrl.sv
module eq_ctrl #(
  parameter int LANES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LANES-1:0] inValid,
  input  logic [LANES-1:0] inTrain,
  output eq_pkg::laneStrobe_t [LANES-1:0] strobe,
  output logic [LANES-1:0] outValid,
  output logic [LANES-1:0] outTrain
);
  localparam int DEPTH = eq_pkg::PIPE_DEPTH;

  logic [LANES-1:0] vPipe [DEPTH];
  logic [LANES-1:0] tPipe [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) begin
        vPipe[k] <= '0;
        tPipe[k] <= '0;
      end
    end else begin
      vPipe[0] <= inValid;
      tPipe[0] <= inTrain;
      for (int k = 1; k < DEPTH; k++) begin
        vPipe[k] <= vPipe[k-1];
        tPipe[k] <= tPipe[k-1];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_strobe
    assign strobe[l].wrEst    = vPipe[0][l] & tPipe[0][l];
    assign strobe[l].selTrain = tPipe[0][l];
  end

  assign outValid = vPipe[DEPTH-1];
  assign outTrain = tPipe[DEPTH-1];
endmodule

// File: rtl/eq_datapath.sv
module eq_datapath #(
  parameter int          PH_W       = 10,
  parameter int          NUM_SC     = 128,
  parameter int          LANES      = 2,
  parameter logic [15:0] TRAIN_MASK = 16'h0049,
  localparam int BANK   = NUM_SC / LANES,
  localparam int SLOT_W = $clog2(BANK)
) (
  input  logic clk,
  input  logic rstN,
  input  eq_pkg::laneStrobe_t [LANES-1:0] strobe,
  input  logic [LANES*PH_W-1:0]   inPhase,
  input  logic [LANES*SLOT_W-1:0] inSlot,
  output logic [LANES*PH_W-1:0]   outPhase,
  output logic [LANES*SLOT_W-1:0] outSlot
);
  localparam int DEPTH = eq_pkg::PIPE_DEPTH;
  localparam logic [PH_W-1:0] HALF_TURN = {1'b1, {(PH_W-1){1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PH_W-1:0]   ph1;
    logic [SLOT_W-1:0] slot1;
    logic [PH_W-1:0]   bank [BANK];
    logic [PH_W-1:0]   resPipe [DEPTH-1];
    logic [SLOT_W-1:0] slotPipe [DEPTH-1];
    logic [15:0]       scIdx;
    logic [PH_W-1:0]   estNew;
    logic [PH_W-1:0]   stage2;

    // stage 1: capture
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ph1   <= '0;
        slot1 <= '0;
      end else begin
        ph1   <= inPhase[l*PH_W +: PH_W];
        slot1 <= inSlot[l*SLOT_W +: SLOT_W];
      end
    end

    // stage 2: sign removal or phase subtraction
    assign scIdx  = 16'(int'(slot1) * LANES + l);
    assign estNew = ph1 + (eq_pkg::trainFlip(scIdx, TRAIN_MASK) ? HALF_TURN : '0);
    assign stage2 = strobe[l].selTrain ? estNew : (ph1 - bank[slot1]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < BANK; e++) bank[e] <= '0;
      end else if (strobe[l].wrEst) begin
        bank[slot1] <= estNew;
      end
    end

    // stages 2..6: result and slot alignment
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < DEPTH-1; k++) begin
          resPipe[k]  <= '0;
          slotPipe[k] <= '0;
        end
      end else begin
        resPipe[0]  <= stage2;
        slotPipe[0] <= slot1;
        for (int k = 1; k < DEPTH-1; k++) begin
          resPipe[k]  <= resPipe[k-1];
          slotPipe[k] <= slotPipe[k-1];
        end
      end
    end

    assign outPhase[l*PH_W +: PH_W]     = resPipe[DEPTH-2];
    assign outSlot[l*SLOT_W +: SLOT_W]  = slotPipe[DEPTH-2];
  end
endmodule

// File: rtl/phase_eq_top.sv
module phase_eq_top #(
  parameter int          PH_W       = 10,
  parameter int          NUM_SC     = 128,
  parameter int          LANES      = 2,
  parameter logic [15:0] TRAIN_MASK = 16'h0049,
  localparam int SLOT_W = $clog2(NUM_SC / LANES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES-1:0]         inValid,
  input  logic [LANES-1:0]         inTrain,
  input  logic [LANES*PH_W-1:0]    inPhase,
  input  logic [LANES*SLOT_W-1:0]  inSlot,
  output logic [LANES-1:0]         outValid,
  output logic [LANES-1:0]         outTrain,
  output logic [LANES*PH_W-1:0]    outPhase,
  output logic [LANES*SLOT_W-1:0]  outSlot
);
  eq_pkg::laneStrobe_t [LANES-1:0] strobe;

  eq_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTrain(inTrain),
    .strobe(strobe), .outValid(outValid), .outTrain(outTrain)
  );

  eq_datapath #(.PH_W(PH_W), .NUM_SC(NUM_SC), .LANES(LANES), .TRAIN_MASK(TRAIN_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inPhase(inPhase), .inSlot(inSlot),
    .outPhase(outPhase), .outSlot(outSlot)
  );
endmodule

// File: rtl/eq_checker.sv
module eq_checker #(
  parameter int          PH_W       = 10,
  parameter int          NUM_SC     = 128,
  parameter int          LANES      = 2,
  parameter logic [15:0] TRAIN_MASK = 16'h0049,
  localparam int SLOT_W = $clog2(NUM_SC / LANES)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [LANES-1:0]         inValid,
  input logic [LANES-1:0]         inTrain,
  input logic [LANES*PH_W-1:0]    inPhase,
  input logic [LANES*SLOT_W-1:0]  inSlot,
  input logic [LANES-1:0]         outValid,
  input logic [LANES-1:0]         outTrain,
  input logic [LANES*PH_W-1:0]    outPhase,
  input logic [LANES*SLOT_W-1:0]  outSlot
);
  localparam int D = eq_pkg::PIPE_DEPTH;
  localparam logic [PH_W-1:0] HALF_TURN = {1'b1, {(PH_W-1){1'b0}}};

  logic [3:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst < 4'd15) sinceRst <= sinceRst + 4'd1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    function automatic logic [PH_W-1:0] trainRef(input logic [PH_W-1:0] p, input logic [SLOT_W-1:0] s);
      return p + (eq_pkg::trainFlip(16'(int'(s) * LANES + l), TRAIN_MASK) ? HALF_TURN : '0);
    endfunction

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst < 4'(D)) |-> !outValid[l]);

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 4'(D)) |-> (outValid[l] == $past(inValid[l], 6)));

    a_r2_tag_latency: assert property (@(posedge clk) disable iff (!rstN)
      ((sinceRst >= 4'(D)) && outValid[l]) |->
        (outTrain[l] == $past(inTrain[l], 6)) &&
        (outSlot[l*SLOT_W +: SLOT_W] == $past(inSlot[l*SLOT_W +: SLOT_W], 6)));

    a_r3_train_phase: assert property (@(posedge clk) disable iff (!rstN)
      ((sinceRst >= 4'(D)) && outValid[l] && outTrain[l]) |->
        (outPhase[l*PH_W +: PH_W] ==
         trainRef($past(inPhase[l*PH_W +: PH_W], 6), $past(inSlot[l*SLOT_W +: SLOT_W], 6))));
  end
endmodule

bind phase_eq_top eq_checker #(.PH_W(PH_W), .NUM_SC(NUM_SC), .LANES(LANES), .TRAIN_MASK(TRAIN_MASK)) u_eq_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTrain(inTrain), .inPhase(inPhase), .inSlot(inSlot),
  .outValid(outValid), .outTrain(outTrain), .outPhase(outPhase), .outSlot(outSlot)
);

// File: tb/tb_phase_eq_top.sv
module tb_phase_eq_top;
  localparam int W = 10, L = 2, SC = 128, BANK = SC / L, SW = 6, D = 6;
  localparam logic [15:0] MASK = 16'h0049;

  logic clk = 1'b0;
  logic rstN;
  logic [L-1:0] inValid, inTrain, outValid, outTrain;
  logic [L*W-1:0] inPhase, outPhase;
  logic [L*SW-1:0] inSlot, outSlot;

  always #10 clk = ~clk;

  phase_eq_top #(.PH_W(W), .NUM_SC(SC), .LANES(L), .TRAIN_MASK(MASK)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTrain(inTrain), .inPhase(inPhase), .inSlot(inSlot),
    .outValid(outValid), .outTrain(outTrain), .outPhase(outPhase), .outSlot(outSlot)
  );

  int nChecks = 0, nErrors = 0, cnt = 0;
  bit finished = 0;
  logic [W-1:0]  est [L][BANK];
  logic          rv [L][8];
  logic          rt [L][8];
  logic [W-1:0]  rp [L][8];
  logic [SW-1:0] rs [L][8];
  string         rtag [L][8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit flipRef(input int lane, input int slot);
    return ^(16'(slot * L + lane) & MASK);
  endfunction

  task automatic checkOut(input int idx);
    for (int l = 0; l < L; l++) begin
      chk(outValid[l] == rv[l][idx], rtag[l][idx], outValid[l], rv[l][idx]);
      if (rv[l][idx]) begin
        chk(outTrain[l] == rt[l][idx], "R2", outTrain[l], rt[l][idx]);
        chk(outSlot[l*SW +: SW] == rs[l][idx], "R2", outSlot[l*SW +: SW], rs[l][idx]);
        chk(outPhase[l*W +: W] == rp[l][idx], rtag[l][idx], outPhase[l*W +: W], rp[l][idx]);
      end
    end
  endtask

  task automatic step(input logic [L-1:0] v, input logic [L-1:0] t,
                      input logic [W-1:0] p0, input logic [W-1:0] p1,
                      input logic [SW-1:0] s0, input logic [SW-1:0] s1, input string tag);
    int idx;
    @(negedge clk);
    if (cnt >= D) checkOut((cnt - D) % 8);
    idx = cnt % 8;
    inValid = v; inTrain = t;
    inPhase = {p1, p0}; inSlot = {s1, s0};
    for (int l = 0; l < L; l++) begin
      logic [W-1:0]  ph;
      logic [SW-1:0] sl;
      ph = (l == 0) ? p0 : p1;
      sl = (l == 0) ? s0 : s1;
      rv[l][idx] = v[l]; rt[l][idx] = t[l]; rs[l][idx] = sl;
      if (v[l] && t[l]) begin
        rp[l][idx] = ph + (flipRef(l, int'(sl)) ? W'(1 << (W-1)) : W'(0));
        est[l][sl] = rp[l][idx];
        rtag[l][idx] = (tag != "") ? tag : "R3";
      end else if (v[l]) begin
        rp[l][idx] = ph - est[l][sl];
        rtag[l][idx] = (tag != "") ? tag : "R4";
      end else begin
        rp[l][idx] = '0;
        rtag[l][idx] = (tag != "") ? tag : "R6";
      end
    end
    cnt++;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int l = 0; l < L; l++) for (int e = 0; e < BANK; e++) est[l][e] = '0;
    rstN = 1'b0; inValid = '0; inTrain = '0; inPhase = '0; inSlot = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet outputs right after reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(outValid == '0, "R1", outValid, 0);
    end
    // R1: untrained estimate is zero
    step(2'b01, 2'b00, 10'h123, 10'h000, 6'd5, 6'd0, "R1");
    // R7: data right after training on the same subcarrier
    step(2'b01, 2'b01, 10'h0F0, 10'h000, 6'd3, 6'd0, "R3");
    step(2'b01, 2'b00, 10'h050, 10'h000, 6'd3, 6'd0, "R7");
    // R8: same slot number on both lanes in one cycle
    step(2'b11, 2'b01, 10'h2AA, 10'h111, 6'd9, 6'd9, "R8");
    step(2'b10, 2'b00, 10'h000, 10'h111, 6'd0, 6'd9, "R8");
    // R9: retraining replaces the estimate (second one wraps via half-turn)
    step(2'b01, 2'b01, 10'h100, 10'h000, 6'd4, 6'd0, "R9");
    step(2'b01, 2'b01, 10'h3FF, 10'h000, 6'd4, 6'd0, "R9");
    step(2'b01, 2'b00, 10'h000, 10'h000, 6'd4, 6'd0, "R9");
    // R5: data leaves the estimate alone
    step(2'b01, 2'b00, 10'h200, 10'h000, 6'd4, 6'd0, "R5");
    step(2'b01, 2'b00, 10'h200, 10'h000, 6'd4, 6'd0, "R5");
    // R6: invalid training stores nothing
    step(2'b00, 2'b01, 10'h077, 10'h000, 6'd4, 6'd0, "R6");
    step(2'b01, 2'b00, 10'h200, 10'h000, 6'd4, 6'd0, "R6");
    // random mix of training, data and idle cycles
    for (int n = 0; n < 4000; n++) begin
      logic [L-1:0] rvv, rtt;
      rvv = L'($urandom_range(3)) | L'(($urandom_range(3) != 0) ? 2'b11 : 2'b00);
      rtt = L'($urandom_range(3)) & L'(($urandom_range(2) == 0) ? 2'b11 : 2'b00);
      step(rvv, rtt, W'($urandom), W'($urandom),
           SW'($urandom_range(BANK-1)), SW'($urandom_range(BANK-1)), "");
    end
    for (int n = 0; n < D + 2; n++) step(2'b00, 2'b00, '0, '0, '0, '0, "R6");
    report();
  end
endmodule